// File: doc/BRIEF.md
# Flash Command Register Decoder

This block is the device-side command decoder of a byte-wide, 64K x 8 bulk-erase flash. The chip-enable, output-enable and write-enable pins, together with the address and data buses, arrive asynchronously. A chain of flops brings them into the block clock. A write cycle is recognised from the synchronised pins. It records the address at the start of the pulse and the data at its end, then hands one command to a mode state machine.

The state machine covers normal array reads, identifier reads, erase and program sequences, and the verify steps. Erase and program each need two writes: a setup write, then a confirm write. The erase and program strobes go to an abstract array model. Each strobe stays high until a verify command ends the pulse. Read cycles return one of three things: array data, an identifier byte, or the byte staged by the last verify command. A single supply-ok input stands in for the high-voltage rail. While it is low, the command register is held in read mode.

Top module: `flash_cmd_if`

## Requirements
- R1: A write is taken only while, after synchronisation, chip enable is low, write enable is low and output enable is high. A write pulse with output enable low, or with chip enable high, changes nothing.
- R2: A command's address is the one present when the write condition becomes true, which is when the later of chip enable and write enable falls. Its data is the last value present before the condition ends.
- R3: Writing 20h and then 20h again raises `erase_o`, which stays high until the next accepted write. A 20h followed by any other code except FFh starts no erase.
- R4: Writing 40h and then any address and data (other than data FFh) raises `prog_o`. `arr_addr_o` and `arr_wdata_o` hold that address and data while the strobe is high.
- R5: Writing A0h during an erase drops `erase_o`. Until the next write, `arr_addr_o` holds the address of the A0h write, whatever address the bus presents, and reads return the array byte there.
- R6: Writing C0h during a program drops `prog_o`. Until the next write, reads return the array byte at the address of the C0h write, whatever address the bus presents.
- R7: Writing 80h or 90h selects identifier reads. A read address with bit 0 clear returns 01h, and with bit 0 set returns the `DEV_CODE` parameter. Both bytes have odd parity over all eight bits, with bit 7 as the parity bit.
- R8: Writing FFh from read, identifier or verify mode returns to array reads. Any unrecognised code does the same.
- R9: After an erase or program setup, one FFh write leaves the setup pending: a later confirm 20h, or a later program data byte, still starts the operation. A second consecutive FFh returns to array reads. A data byte of FFh starts no program pulse.
- R10: While `vpp_hi_i` is low (after synchronisation), the mode is forced to array reads and every write is discarded. Both strobes drop within one cycle of the synchronised flag going low.
- R11: `dq_oe_o` is high exactly while the synchronised pins show chip enable low, output enable low and write enable high. In read mode, `dq_o` returns `arr_rdata_i` for the bus address.
- R12: `erase_o` and `prog_o` are never high together. Each strobe falls only on an accepted write or on loss of the supply flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_ni | input | 1 | Chip enable, active low, asynchronous |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| we_ni | input | 1 | Write enable, active low, asynchronous |
| vpp_hi_i | input | 1 | High-voltage supply present |
| addr_i | input | AW | Bus address |
| dq_i | input | 8 | Bus write data |
| dq_o | output | 8 | Bus read data |
| dq_oe_o | output | 1 | Bus output drive enable |
| arr_addr_o | output | AW | Array address |
| arr_wdata_o | output | 8 | Byte being programmed |
| arr_rdata_i | input | 8 | Array read data |
| erase_o | output | 1 | Bulk erase strobe |
| prog_o | output | 1 | Byte program strobe |

## Verification
The bench moves the address and the data in the middle of a write pulse. A decoder that latched either one at the wrong edge would program the wrong byte, or program the right byte with the wrong value. During verify, the bus reads from a different address than the staged one. A design that kept following the bus would return the wrong byte. The cancel sequences use one FFh and then two FFh writes. A design that cancelled on the first FFh would miss the later confirm, and one that never cancelled would start a stray erase or program. Writes with output enable low or chip enable high, writes made with the supply flag low, and a supply drop during an erase all check that a blocked operation leaves the strobes and the read mode unchanged.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [3:0] {
    MD_READ,
    MD_ID,
    MD_ERS_SETUP,
    MD_ERS_ARM,
    MD_ERASE,
    MD_ERS_VFY,
    MD_PRG_SETUP,
    MD_PRG_ARM,
    MD_PROGRAM,
    MD_PRG_VFY
  } mode_e;

  localparam byte_t CMD_ERS  = 8'h20;
  localparam byte_t CMD_PRG  = 8'h40;
  localparam byte_t CMD_ID0  = 8'h80;
  localparam byte_t CMD_ID1  = 8'h90;
  localparam byte_t CMD_EVFY = 8'hA0;
  localparam byte_t CMD_PVFY = 8'hC0;
  localparam byte_t CMD_RST  = 8'hFF;
endpackage

// File: rtl/flash_bus_sync.sv
module flash_bus_sync
  import flash_cmd_pkg::*;
#(
  parameter int AW     = 16,
  parameter int STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          oe_ni,
  input  logic          we_ni,
  input  logic          vpp_hi_i,
  input  logic [AW-1:0] addr_i,
  input  byte_t         dq_i,
  output logic          ce_n_o,
  output logic          oe_n_o,
  output logic          we_n_o,
  output logic          vpp_o,
  output logic [AW-1:0] addr_o,
  output byte_t         dq_o
);
  localparam int W = 4 + AW + BYTE_W;
  // pins idle high, supply absent, buses zero
  localparam logic [W-1:0] RST_V = {3'b111, 1'b0, {(AW + BYTE_W){1'b0}}};

  logic [STAGES-1:0][W-1:0] stg_q;
  logic [W-1:0]             bundle;

  assign bundle = {ce_ni, oe_ni, we_ni, vpp_hi_i, addr_i, dq_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_V;
    end else begin
      stg_q[0] <= bundle;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign {ce_n_o, oe_n_o, we_n_o, vpp_o, addr_o, dq_o} = stg_q[STAGES-1];
endmodule

// File: rtl/flash_wr_latch.sv
module flash_wr_latch
  import flash_cmd_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_n_i,
  input  logic          oe_n_i,
  input  logic          we_n_i,
  input  logic [AW-1:0] addr_i,
  input  byte_t         dq_i,
  output logic          wr_act_o,
  output logic          rd_act_o,
  output logic          cmd_v_o,
  output logic [AW-1:0] cmd_addr_o,
  output byte_t         cmd_data_o
);
  logic wr_q;

  assign wr_act_o = !ce_n_i && !we_n_i && oe_n_i;
  assign rd_act_o = !ce_n_i && !oe_n_i && we_n_i;
  assign cmd_v_o  = wr_q && !wr_act_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q       <= 1'b0;
      cmd_addr_o <= '0;
      cmd_data_o <= '0;
    end else begin
      wr_q <= wr_act_o;
      // address at the later falling edge, data tracked until release
      if (wr_act_o && !wr_q) cmd_addr_o <= addr_i;
      if (wr_act_o)          cmd_data_o <= dq_i;
    end
  end
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vpp_ok_i,
  input  logic          cmd_v_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  byte_t         cmd_data_i,
  output mode_e         mode_o,
  output logic [AW-1:0] prog_addr_o,
  output byte_t         prog_data_o,
  output logic [AW-1:0] vfy_addr_o,
  output logic          erase_o,
  output logic          prog_o
);
  mode_e         mode_q, mode_d;
  logic [AW-1:0] pa_q, pa_d, va_q, va_d;
  byte_t         pd_q, pd_d;

  always_comb begin
    mode_d = mode_q;
    pa_d   = pa_q;
    pd_d   = pd_q;
    va_d   = va_q;
    if (!vpp_ok_i) begin
      mode_d = MD_READ;
    end else if (cmd_v_i) begin
      unique case (mode_q)
        MD_ERS_SETUP: begin
          if (cmd_data_i == CMD_ERS)      mode_d = MD_ERASE;
          else if (cmd_data_i == CMD_RST) mode_d = MD_ERS_ARM;
          else                            mode_d = MD_READ;
        end
        MD_ERS_ARM: mode_d = (cmd_data_i == CMD_ERS) ? MD_ERASE : MD_READ;
        MD_ERASE: begin
          if (cmd_data_i == CMD_EVFY) begin
            mode_d = MD_ERS_VFY;
            va_d   = cmd_addr_i;
          end else begin
            mode_d = MD_READ;
          end
        end
        MD_PRG_SETUP, MD_PRG_ARM: begin
          if (cmd_data_i == CMD_RST) begin
            mode_d = (mode_q == MD_PRG_SETUP) ? MD_PRG_ARM : MD_READ;
          end else begin
            mode_d = MD_PROGRAM;
            pa_d   = cmd_addr_i;
            pd_d   = cmd_data_i;
          end
        end
        MD_PROGRAM: begin
          if (cmd_data_i == CMD_PVFY) begin
            mode_d = MD_PRG_VFY;
            va_d   = cmd_addr_i;
          end else begin
            mode_d = MD_READ;
          end
        end
        default: begin
          case (cmd_data_i)
            CMD_ID0, CMD_ID1: mode_d = MD_ID;
            CMD_ERS:          mode_d = MD_ERS_SETUP;
            CMD_PRG:          mode_d = MD_PRG_SETUP;
            CMD_EVFY: begin
              // repeat verify walks the erased range
              if (mode_q == MD_ERS_VFY) begin
                mode_d = MD_ERS_VFY;
                va_d   = cmd_addr_i;
              end else begin
                mode_d = MD_READ;
              end
            end
            default:          mode_d = MD_READ;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MD_READ;
      pa_q   <= '0;
      pd_q   <= '0;
      va_q   <= '0;
    end else begin
      mode_q <= mode_d;
      pa_q   <= pa_d;
      pd_q   <= pd_d;
      va_q   <= va_d;
    end
  end

  assign mode_o      = mode_q;
  assign prog_addr_o = pa_q;
  assign prog_data_o = pd_q;
  assign vfy_addr_o  = va_q;
  assign erase_o     = (mode_q == MD_ERASE);
  assign prog_o      = (mode_q == MD_PROGRAM);
endmodule

// File: rtl/flash_rd_mux.sv
module flash_rd_mux
  import flash_cmd_pkg::*;
#(
  parameter int    AW       = 16,
  parameter byte_t MFR_CODE = 8'h01,
  parameter byte_t DEV_CODE = 8'h25
) (
  input  mode_e         mode_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [AW-1:0] prog_addr_i,
  input  logic [AW-1:0] vfy_addr_i,
  input  byte_t         arr_rdata_i,
  output logic [AW-1:0] arr_addr_o,
  output byte_t         dq_o
);
  always_comb begin
    unique case (mode_i)
      MD_PROGRAM:             arr_addr_o = prog_addr_i;
      MD_ERS_VFY, MD_PRG_VFY: arr_addr_o = vfy_addr_i;
      default:                arr_addr_o = bus_addr_i;
    endcase
  end

  always_comb begin
    if (mode_i == MD_ID) dq_o = bus_addr_i[0] ? DEV_CODE : MFR_CODE;
    else                 dq_o = arr_rdata_i;
  end
endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import flash_cmd_pkg::*;
#(
  parameter int    AW          = 16,
  parameter int    SYNC_STAGES = 2,
  parameter byte_t MFR_CODE    = 8'h01,
  parameter byte_t DEV_CODE    = 8'h25
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          oe_ni,
  input  logic          we_ni,
  input  logic          vpp_hi_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    dq_i,
  output logic [7:0]    dq_o,
  output logic          dq_oe_o,
  output logic [AW-1:0] arr_addr_o,
  output logic [7:0]    arr_wdata_o,
  input  logic [7:0]    arr_rdata_i,
  output logic          erase_o,
  output logic          prog_o
);
  logic          ce_s, oe_s, we_s, vpp_s;
  logic [AW-1:0] addr_s;
  byte_t         dq_s;
  logic          wr_act, rd_act, cmd_v;
  logic [AW-1:0] cmd_addr, prog_addr, vfy_addr;
  byte_t         cmd_data;
  mode_e         mode;

  flash_bus_sync #(.AW(AW), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .ce_ni, .oe_ni, .we_ni, .vpp_hi_i, .addr_i, .dq_i,
    .ce_n_o(ce_s), .oe_n_o(oe_s), .we_n_o(we_s), .vpp_o(vpp_s),
    .addr_o(addr_s), .dq_o(dq_s)
  );

  flash_wr_latch #(.AW(AW)) u_wr (
    .clk_i, .rst_ni, .ce_n_i(ce_s), .oe_n_i(oe_s), .we_n_i(we_s),
    .addr_i(addr_s), .dq_i(dq_s), .wr_act_o(wr_act), .rd_act_o(rd_act),
    .cmd_v_o(cmd_v), .cmd_addr_o(cmd_addr), .cmd_data_o(cmd_data)
  );

  flash_cmd_fsm #(.AW(AW)) u_fsm (
    .clk_i, .rst_ni, .vpp_ok_i(vpp_s), .cmd_v_i(cmd_v),
    .cmd_addr_i(cmd_addr), .cmd_data_i(cmd_data), .mode_o(mode),
    .prog_addr_o(prog_addr), .prog_data_o(arr_wdata_o),
    .vfy_addr_o(vfy_addr), .erase_o, .prog_o
  );

  flash_rd_mux #(.AW(AW), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_rd (
    .mode_i(mode), .bus_addr_i(addr_s), .prog_addr_i(prog_addr),
    .vfy_addr_i(vfy_addr), .arr_rdata_i, .arr_addr_o, .dq_o
  );

  assign dq_oe_o = rd_act;
endmodule

// File: rtl/flash_cmd_if_chk.sv
module flash_cmd_if_chk
  import flash_cmd_pkg::*;
#(
  parameter byte_t MFR_CODE = 8'h01,
  parameter byte_t DEV_CODE = 8'h25
) (
  input logic  clk_i,
  input logic  rst_ni,
  input logic  erase_o,
  input logic  prog_o,
  input byte_t dq_o,
  input logic  dq_oe_o,
  input mode_e mode,
  input logic  cmd_v,
  input logic  wr_act,
  input logic  vpp_ok
);
  // R7
  initial begin
    id_code_parity_chk: assert ((^DEV_CODE) && (^MFR_CODE));
  end

  // R12
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(erase_o && prog_o));

  // R3
  erase_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(erase_o) |-> ($past(mode) == MD_ERS_SETUP || $past(mode) == MD_ERS_ARM));

  // R4
  prog_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prog_o) |-> ($past(mode) == MD_PRG_SETUP || $past(mode) == MD_PRG_ARM));

  // R12
  strobe_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(erase_o) || $fell(prog_o)) |-> ($past(cmd_v) || !$past(vpp_ok)));

  // R10
  vpp_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vpp_ok |=> (!erase_o && !prog_o));

  // R11
  no_drive_in_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_act |-> !dq_oe_o);

  // R7
  id_parity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dq_oe_o && mode == MD_ID) |-> (^dq_o));
endmodule

bind flash_cmd_if flash_cmd_if_chk #(.MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .erase_o(erase_o), .prog_o(prog_o),
  .dq_o(dq_o), .dq_oe_o(dq_oe_o), .mode(mode), .cmd_v(cmd_v),
  .wr_act(wr_act), .vpp_ok(vpp_s)
);

// File: tb/flash_cmd_if_bench.sv
module flash_cmd_if_bench;
  localparam int         AW  = 16;
  localparam logic [7:0] DEV = 8'h25;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, vpp = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    dq_in = '0;
  logic [7:0]    dq_out, wdata, rdata;
  logic          dq_oe, erase, prog;
  logic [AW-1:0] arr_addr;
  logic [7:0]    mem [256];
  int            n_chk = 0, n_fail = 0;

  always #2.5ns clk = ~clk;

  flash_cmd_if #(.AW(AW), .DEV_CODE(DEV)) u_flash_cmd_if (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .vpp_hi_i(vpp), .addr_i(addr), .dq_i(dq_in), .dq_o(dq_out),
    .dq_oe_o(dq_oe), .arr_addr_o(arr_addr), .arr_wdata_o(wdata),
    .arr_rdata_i(rdata), .erase_o(erase), .prog_o(prog)
  );

  // abstract array: erase sets all ones, program clears bits
  assign rdata = mem[arr_addr[7:0]];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
    end else if (erase) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'hFF;
    end else if (prog) begin
      mem[arr_addr[7:0]] <= mem[arr_addr[7:0]] & wdata;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_ext(input logic [AW-1:0] a1, input logic [7:0] d1,
                        input logic [AW-1:0] a2, input logic [7:0] d2,
                        input logic oe_lvl, input logic ce_lvl);
    @(negedge clk);
    addr = a1; dq_in = d1; oe_n = oe_lvl; ce_n = ce_lvl; we_n = 1'b0;
    repeat (3) @(negedge clk);
    addr = a2; dq_in = d2;
    repeat (3) @(negedge clk);
    we_n = 1'b1;
    repeat (2) @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [7:0] d);
    wr_ext(a, d, a, d, 1'b1, 1'b0);
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [7:0] d, output logic en);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    repeat (4) @(negedge clk);
    d = dq_out; en = dq_oe;
    ce_n = 1'b1; oe_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d; logic en;
    chk("R11 idle no drive", {15'b0, dq_oe}, 16'h0);
    chk("R12 reset erase", {15'b0, erase}, 16'h0);
    chk("R12 reset prog", {15'b0, prog}, 16'h0);
    bus_rd(16'h0010, d, en);
    chk("R11 array read", {8'h0, d}, 16'h004A);
    chk("R11 read drive", {15'b0, en}, 16'h1);
  endtask

  task automatic t_ident();
    logic [7:0] d; logic en;
    bus_wr(16'h0000, 8'h90);
    bus_rd(16'h0000, d, en);
    chk("R7 mfr code", {8'h0, d}, 16'h0001);
    bus_rd(16'h0001, d, en);
    chk("R7 dev code", {8'h0, d}, {8'h0, DEV});
    chk("R7 odd parity", {15'b0, ^d}, 16'h1);
    bus_wr(16'h0000, 8'hFF);
    bus_rd(16'h0001, d, en);
    chk("R8 reset to read", {8'h0, d}, 16'h005B);
    bus_wr(16'h0000, 8'h80);
    bus_rd(16'h0000, d, en);
    chk("R7 alt id code", {8'h0, d}, 16'h0001);
    bus_wr(16'h0000, 8'h33);
    bus_rd(16'h0000, d, en);
    chk("R8 unknown code", {8'h0, d}, 16'h005A);
  endtask

  task automatic t_qualify();
    logic [7:0] d; logic en;
    wr_ext(16'h0000, 8'h90, 16'h0000, 8'h90, 1'b0, 1'b0);
    bus_rd(16'h0000, d, en);
    chk("R1 oe low blocks", {8'h0, d}, 16'h005A);
    wr_ext(16'h0000, 8'h90, 16'h0000, 8'h90, 1'b1, 1'b1);
    bus_rd(16'h0000, d, en);
    chk("R1 ce high blocks", {8'h0, d}, 16'h005A);
  endtask

  task automatic t_program();
    logic [7:0] d; logic en;
    bus_wr(16'h0000, 8'h40);
    wr_ext(16'h0021, 8'hF0, 16'h0022, 8'h0F, 1'b1, 1'b0);
    chk("R4 prog strobe", {15'b0, prog}, 16'h1);
    chk("R12 no erase in prog", {15'b0, erase}, 16'h0);
    chk("R2 addr at start", arr_addr, 16'h0021);
    chk("R2 R4 data at end", {8'h0, wdata}, 16'h000F);
    bus_wr(16'h0021, 8'hC0);
    chk("R6 verify ends pulse", {15'b0, prog}, 16'h0);
    bus_rd(16'h0030, d, en);
    chk("R6 verify byte", {8'h0, d}, 16'h000B);
    bus_wr(16'h0000, 8'hFF);
  endtask

  task automatic t_erase();
    logic [7:0] d; logic en;
    bus_wr(16'h0000, 8'h20);
    bus_wr(16'h0000, 8'h30);
    chk("R3 bad confirm", {15'b0, erase}, 16'h0);
    bus_rd(16'h0010, d, en);
    chk("R8 read after bad confirm", {8'h0, d}, 16'h004A);
    bus_wr(16'h0000, 8'h20);
    bus_wr(16'h0000, 8'h20);
    chk("R3 erase strobe", {15'b0, erase}, 16'h1);
    chk("R12 no prog in erase", {15'b0, prog}, 16'h0);
    bus_wr(16'h0005, 8'hA0);
    chk("R5 verify ends erase", {15'b0, erase}, 16'h0);
    @(negedge clk);
    addr = 16'h0040; ce_n = 1'b0; oe_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R5 verify address", arr_addr, 16'h0005);
    chk("R5 erased byte", {8'h0, dq_out}, 16'h00FF);
    ce_n = 1'b1; oe_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_wr(16'h0000, 8'hFF);
  endtask

  task automatic t_cancel();
    bus_wr(16'h0000, 8'h20);
    bus_wr(16'h0000, 8'hFF);
    bus_wr(16'h0000, 8'h20);
    chk("R9 one FF keeps erase setup", {15'b0, erase}, 16'h1);
    bus_wr(16'h0000, 8'hA0);
    bus_wr(16'h0000, 8'hFF);
    bus_wr(16'h0000, 8'h20);
    bus_wr(16'h0000, 8'hFF);
    bus_wr(16'h0000, 8'hFF);
    bus_wr(16'h0000, 8'h20);
    chk("R9 two FF cancel erase", {15'b0, erase}, 16'h0);
    bus_wr(16'h0000, 8'hFF);
    bus_wr(16'h0000, 8'hFF);
    bus_wr(16'h0000, 8'h40);
    bus_wr(16'h0050, 8'hFF);
    chk("R9 FF data no pulse", {15'b0, prog}, 16'h0);
    bus_wr(16'h0050, 8'hFF);
    bus_wr(16'h0050, 8'h00);
    chk("R9 two FF cancel prog", {15'b0, prog}, 16'h0);
    bus_wr(16'h0000, 8'h40);
    bus_wr(16'h0051, 8'hFF);
    bus_wr(16'h0051, 8'h3C);
    chk("R9 armed prog starts", {15'b0, prog}, 16'h1);
    chk("R9 armed prog data", {8'h0, wdata}, 16'h003C);
    bus_wr(16'h0051, 8'hC0);
    bus_wr(16'h0000, 8'hFF);
  endtask

  task automatic t_vpp();
    logic [7:0] d; logic en;
    @(negedge clk); vpp = 1'b0;
    repeat (4) @(negedge clk);
    bus_wr(16'h0000, 8'h20);
    bus_wr(16'h0000, 8'h20);
    chk("R10 erase blocked", {15'b0, erase}, 16'h0);
    bus_wr(16'h0000, 8'h90);
    bus_rd(16'h0000, d, en);
    chk("R10 id blocked", {8'h0, d}, 16'h00FF);
    vpp = 1'b1;
    repeat (4) @(negedge clk);
    bus_wr(16'h0000, 8'h20);
    bus_wr(16'h0000, 8'h20);
    chk("R10 erase with supply", {15'b0, erase}, 16'h1);
    vpp = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10 supply loss ends erase", {15'b0, erase}, 16'h0);
    vpp = 1'b1;
    repeat (4) @(negedge clk);
    bus_wr(16'h0000, 8'h33);
    bus_rd(16'h0010, d, en);
    chk("R10 back in read", {8'h0, d}, 16'h00FF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_ident();
    t_qualify();
    t_program();
    t_erase();
    t_cancel();
    t_vpp();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule